// File: doc/BRIEF.md
# Gated Controlled-Time Clock Generator

This block derives a controlled clock for a design under test from a free-running clock. The surrounding message machinery uses it to stop modelled time while transactions are still being moved or processed. Rising and falling transitions of the controlled clock each have their own enable. The output can therefore be frozen high or frozen low, and the design under test sees no edge while transport is busy.

The block runs synchronously on a double-rate input clock. It divides that clock into an uncontrolled reference clock, which toggles on every input edge. At each reference transition the matching enable is sampled, and the registered controlled clock either follows the reference or keeps its level.

A bank of hold outputs drives the data-holding latches in front of the design under test. These outputs are asserted whenever the latest reference transition was not passed on, so the design's data stays still while its clock is paused. A counter of controlled rising edges lets a test compare modelled cycles against reference cycles.

Top module: `ctl_clock_gen`

## Requirements
- R1: While reset is asserted, and until the first functional input edge after the synchronised release, the reference clock and the controlled clock are 0, every hold lane is 1 and the cycle count is 0.
- R2: After reset the reference clock inverts on every rising edge of the double-rate input clock, starting with a 0-to-1 transition.
- R3: The controlled clock goes from 0 to 1 only on an input edge at which the reference clock goes from 0 to 1 and the rise enable is 1 at that edge.
- R4: With the rise enable at 0 at a reference rising transition, the controlled clock does not rise; falling is still allowed at the next falling transition.
- R5: The controlled clock goes from 1 to 0 only at a reference falling transition with the fall enable at 1; with the fall enable at 0 it holds its level.
- R6: After every input edge, all hold lanes are 0 if the controlled clock changed level at that edge and are 1 otherwise, so a controlled clock frozen at either level keeps the hold lanes at 1.
- R7: The cycle count increments by one at each controlled rising transition, never otherwise, and wraps modulo 2^CNT_W.
- R8: The rise enable is ignored at reference falling transitions and the fall enable is ignored at reference rising transitions; an enable affects only its matching edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Free-running clock at twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rise_en | input | 1 | Permits a controlled rising transition at the next reference rise |
| fall_en | input | 1 | Permits a controlled falling transition at the next reference fall |
| ref_clk | output | 1 | Uncontrolled reference clock, half the input rate |
| ctl_clk | output | 1 | Registered controlled clock for the design under test |
| hold | output | HOLD_LANES | Hold enables for the data-holding latches, 1 = freeze |
| mcycles | output | CNT_W | Count of controlled rising transitions |

## Verification
The bench builds the block with CNT_W = 4 and HOLD_LANES = 3. The narrow counter makes the modulo wrap of the modelled-cycle count reachable within a few dozen reference cycles. Three lanes show that every lane of the generated hold bank follows the same rule. The stimulus table drives every combination of the two enables at both reference phases, covering freezes at high and at low, release from a freeze, and enables that are offered only at the non-matching phase.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  // Level of the uncontrolled reference clock held inside the block.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Transitions granted to the controlled clock at one input edge.
  typedef struct packed {
    logic rise_go;
    logic fall_go;
  } edge_evt_t;

endpackage

// File: rtl/ccg_rst_sync.sv
module ccg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/ccg_phase.sv
module ccg_phase
  import ccg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_q
);

  phase_e phase_d;

  always_comb begin
    if (phase_q == PH_LOW) begin
      phase_d = PH_HIGH;
    end else begin
      phase_d = PH_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/ccg_edge_gate.sv
module ccg_edge_gate
  import ccg_pkg::*;
#(
  parameter int HOLD_LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  phase_e                phase_q,
  input  logic                  rise_en,
  input  logic                  fall_en,
  output logic                  ctl_q,
  output logic [HOLD_LANES-1:0] hold_q,
  output edge_evt_t             evt
);

  logic ctl_d;
  logic ctl_ce;
  logic hold_d;

  // The current phase names the reference transition taken at this edge.
  always_comb begin
    evt.rise_go = (phase_q == PH_LOW)  && rise_en && !ctl_q;
    evt.fall_go = (phase_q == PH_HIGH) && fall_en &&  ctl_q;
    ctl_ce      = evt.rise_go || evt.fall_go;
    ctl_d       = evt.rise_go;
    hold_d      = !ctl_ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

  // One flop per lane, so each latch group gets a local copy of the hold.
  for (genvar g = 0; g < HOLD_LANES; g++) begin : g_hold_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[g] <= 1'b1;
      end else begin
        hold_q[g] <= hold_d;
      end
    end
  end

endmodule

// File: rtl/ccg_cycle_cnt.sv
module ccg_cycle_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/ctl_clock_gen.sv
module ctl_clock_gen
  import ccg_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int HOLD_LANES = 4
) (
  input  logic                  clk_2x,
  input  logic                  rst_n,
  input  logic                  rise_en,
  input  logic                  fall_en,
  output logic                  ref_clk,
  output logic                  ctl_clk,
  output logic [HOLD_LANES-1:0] hold,
  output logic [CNT_W-1:0]      mcycles
);

  logic      rst_q;
  phase_e    phase_q;
  edge_evt_t evt;

  ccg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk_2x),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  ccg_phase u_phase (
    .clk     (clk_2x),
    .rst_n   (rst_q),
    .phase_q (phase_q)
  );

  ccg_edge_gate #(.HOLD_LANES(HOLD_LANES)) u_gate (
    .clk     (clk_2x),
    .rst_n   (rst_q),
    .phase_q (phase_q),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .ctl_q   (ctl_clk),
    .hold_q  (hold),
    .evt     (evt)
  );

  ccg_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk_2x),
    .rst_n   (rst_q),
    .inc     (evt.rise_go),
    .count_q (mcycles)
  );

  assign ref_clk = (phase_q == PH_HIGH);

endmodule

// File: rtl/ctl_clock_gen_chk.sv
module ctl_clock_gen_chk #(
  parameter int CNT_W      = 32,
  parameter int HOLD_LANES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rise_en,
  input logic                  fall_en,
  input logic                  ref_clk,
  input logic                  ctl_clk,
  input logic [HOLD_LANES-1:0] hold,
  input logic [CNT_W-1:0]      mcycles
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_ref_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_clk != $past(ref_clk)));

  p_rise_on_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_clk) |-> $rose(ref_clk));

  p_rise_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_clk && !rise_en) |=> !$rose(ctl_clk));

  p_fall_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clk && !fall_en) |=> !$fell(ctl_clk));

  p_fall_on_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_clk) |-> $fell(ref_clk));

  p_hold_moving_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_clk) || $fell(ctl_clk)) |-> (hold == '0));

  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctl_clk) |-> (&hold));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_clk) |-> (mcycles == $past(mcycles) + ONE));

  p_count_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ctl_clk) |-> $stable(mcycles));

  p_rise_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clk && !fall_en) |=> $stable(ctl_clk));

endmodule

bind ctl_clock_gen ctl_clock_gen_chk #(
  .CNT_W      (CNT_W),
  .HOLD_LANES (HOLD_LANES)
) u_chk (
  .clk     (clk_2x),
  .rst_n   (rst_q),
  .rise_en (rise_en),
  .fall_en (fall_en),
  .ref_clk (ref_clk),
  .ctl_clk (ctl_clk),
  .hold    (hold),
  .mcycles (mcycles)
);

// File: tb/ctl_clock_gen_tb.sv
module ctl_clock_gen_tb;

  localparam int CLK_P  = 10;
  localparam int CNT_W  = 4;
  localparam int LANES  = 3;
  localparam int NVEC   = 24;
  localparam int WDOG   = 200000;

  // Each entry: {rise_en, fall_en} for one input edge; even entries land on
  // reference rising transitions, odd entries on falling ones.
  localparam logic [1:0] VEC [NVEC] = '{
    2'b11, 2'b11, 2'b11, 2'b11,   // free running
    2'b00, 2'b00, 2'b00, 2'b00,   // frozen low
    2'b10, 2'b00, 2'b10, 2'b00,   // frozen high
    2'b00, 2'b01, 2'b00, 2'b00,   // fall allowed, rise blocked
    2'b01, 2'b10, 2'b01, 2'b10,   // enables only at wrong phase (R8)
    2'b10, 2'b01, 2'b11, 2'b11    // recover
  };

  logic             clk_2x;
  logic             rst_n;
  logic             rise_en;
  logic             fall_en;
  logic             ref_clk;
  logic             ctl_clk;
  logic [LANES-1:0] hold;
  logic [CNT_W-1:0] mcycles;

  int checks;
  int errors;

  logic             m_ref;
  logic             m_ctl;
  logic             m_hold;
  logic [CNT_W-1:0] m_cnt;

  ctl_clock_gen #(.CNT_W(CNT_W), .HOLD_LANES(LANES)) u_dut (
    .clk_2x  (clk_2x),
    .rst_n   (rst_n),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .ref_clk (ref_clk),
    .ctl_clk (ctl_clk),
    .hold    (hold),
    .mcycles (mcycles)
  );

  initial begin
    clk_2x = 1'b0;
    forever #(CLK_P/2) clk_2x = ~clk_2x;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic check_reset_state();
    check("R1", "ref_clk", 32'(ref_clk), 32'd0);
    check("R1", "ctl_clk", 32'(ctl_clk), 32'd0);
    check("R1", "hold", 32'(hold), 32'((1 << LANES) - 1));
    check("R1", "mcycles", 32'(mcycles), 32'd0);
  endtask

  task automatic model_reset();
    m_ref  = 1'b0;
    m_ctl  = 1'b0;
    m_hold = 1'b1;
    m_cnt  = '0;
  endtask

  // Drive one edge's enables, advance the model, compare after the edge.
  task automatic step(input logic r, input logic f, input string tag);
    logic was_ref;
    logic prev_ctl;
    string creq;
    rise_en = r;
    fall_en = f;
    @(posedge clk_2x);
    was_ref  = m_ref;
    prev_ctl = m_ctl;
    m_ref    = !m_ref;
    if (!was_ref) begin
      if (r && !m_ctl) begin
        m_ctl = 1'b1;
        m_cnt = m_cnt + 1'b1;
      end
    end else begin
      if (f && m_ctl) m_ctl = 1'b0;
    end
    m_hold = (m_ctl == prev_ctl);
    if (!was_ref) creq = r ? "R3" : "R4";
    else          creq = "R5";
    if (tag != "") creq = tag;
    @(negedge clk_2x);
    check("R2", "ref_clk", 32'(ref_clk), 32'(m_ref));
    check(creq, "ctl_clk", 32'(ctl_clk), 32'(m_ctl));
    check("R6", "hold", 32'(hold), m_hold ? 32'((1 << LANES) - 1) : 32'd0);
    check("R7", "mcycles", 32'(mcycles), 32'(m_cnt));
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    rise_en = 1'b0;
    fall_en = 1'b0;
    model_reset();
    repeat (2) @(negedge clk_2x);
    check_reset_state();
    rst_n = 1'b1;
    // Two synchroniser stages: the block stays in reset through two edges.
    repeat (2) @(negedge clk_2x);
    check_reset_state();
  endtask

  initial begin
    #(CLK_P * WDOG);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    rise_en = 1'b0;
    fall_en = 1'b0;
    @(negedge clk_2x);
    do_reset();

    // Table walk.
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][1], VEC[i][0], ((i >= 16) && (i < 20)) ? "R8" : "");
    end

    // Align to a reference rising transition.
    if (m_ref) step(1'b0, 1'b1, "");

    // Frozen high: rise granted, falls refused for several edges (R5, R6).
    step(1'b1, 1'b0, "");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R5");

    // Wrong-phase enables keep the clock where it is (R8).
    step(1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R8");

    // Counter wrap: run freely past 2^CNT_W rising transitions (R7).
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, "R7");
    check("R7", "wrap value", 32'(mcycles), 32'(m_cnt));

    // Asynchronous reset in the middle of a run (R1).
    @(negedge clk_2x);
    #1;
    rst_n = 1'b0;
    #1;
    check_reset_state();
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule